// File: doc/BRIEF.md
# Chunked Sparse Weight Stream Decoder

This block sits between a 64-bit coprocessor data port and a four-multiplier sparse processing element. The port delivers a sparse weight matrix that has been cut into chunks of four rows. Each chunk is described by a small header and followed by one to four value words. A value word carries four 16-bit weights, one for each row of the chunk. One header word always describes two chunks. The decoder therefore works through the values of the first chunk, then through the values of the second chunk, before it takes the next header word.

A header word is absorbed without producing any output. Each value word is passed straight through as four lanes. Every lane carries the row-permutation index of its row, the encoded column index for that row, and the 16-bit weight. Both indices come from the header of the chunk that is currently being drained. A one-cycle strobe marks the transfer of the last value word of each chunk. The input side uses a valid/ready handshake. The ready that comes back from the downstream element stalls both the input and the internal word count. A synchronous start pulse abandons whatever is in flight and makes the decoder wait for a header word.

Top module: `sell_stream_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, the decoder waits for a header word: in_ready is 1, lane_valid is 0, chunk_done is 0, and row_idx, col_code and value are all 0.
- R2: In the waiting state, any valid input word is taken as a header word. It is accepted with in_ready=1 and produces lane_valid=0 and chunk_done=0 in that cycle.
- R3: Header layout, counted from bit 0: chunk A has row indices in [11:0], column codes in [23:12] and width in [25:24]. Chunk B has row indices in [37:26], column codes in [49:38] and width in [51:50]. Bits [63:52] are ignored.
- R4: After a header, exactly widthA+1 value words are taken as chunk A. During these words, row_idx and col_code show chunk A's fields.
- R5: After chunk A, exactly widthB+1 value words are taken as chunk B, with chunk B's fields on row_idx and col_code. The decoder then waits for a header again.
- R6: For a value word, lane k (k=0..3) has value[16k+15:16k] = in_data[16k+15:16k], row_idx[3k+2:3k] = row field k, and col_code[3k+2:3k] = column field k. Here field k of a 12-bit index group is its bits [3k+2:3k].
- R7: chunk_done is 1 only in the cycle in which the last value word of a chunk is transferred (in_valid=1 and out_ready=1).
- R8: While a chunk is being drained, in_ready equals out_ready. A word that is not transferred leaves the remaining count, row_idx and col_code unchanged.
- R9: In a cycle with start=1, in_ready=0, lane_valid=0 and chunk_done=0. The next cycle waits for a header, whatever state the decoder was in before.
- R10: lane_valid is 4'b1111 exactly when the decoder is draining a chunk, in_valid=1 and start=0. Otherwise it is 4'b0000, and value is then 0.

Top module ports follow in list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart; the decoder then waits for a header |
| in_valid | input | 1 | Input word valid |
| in_data | input | 64 | Input word: header or value word |
| in_ready | output | 1 | Input word accepted when in_valid is also 1 |
| out_ready | input | 1 | Processing element can take the lanes |
| lane_valid | output | 4 | Per-lane valid |
| row_idx | output | 12 | Four 3-bit row-permutation indices, lane k at [3k+2:3k] |
| col_code | output | 12 | Four 3-bit encoded column indices, lane k at [3k+2:3k] |
| value | output | 64 | Four 16-bit weights, lane k at [16k+15:16k] |
| chunk_done | output | 1 | Last value word of a chunk is being transferred |

## Verification
The first directed pattern uses chunk widths of one and four words and sets the unused header bits. This separates a decoder that counts each chunk from its own width field from one that reuses the first width or reads the junk bits. The second pattern uses the opposite widths and lowers the downstream ready in the middle of a chunk. This exposes a counter that advances on presentation instead of on transfer. The third pattern fires a start pulse in the middle of a chunk, which shows whether the restart really drops the pending values. A long stretch of random validity, ready, data and occasional start pulses is then compared cycle by cycle against a behavioural model. This covers back-to-back chunks and headers that arrive right after a restart.

// File: rtl/sell_pkg.sv
package sell_pkg;
  localparam int unsigned LANES         = 4;
  localparam int unsigned IDX_W         = 3;
  localparam int unsigned VAL_W         = 16;
  localparam int unsigned CW_W          = 2;
  localparam int unsigned HDRS_PER_WORD = 2;
  localparam int unsigned WORD_W        = LANES * VAL_W;
  localparam int unsigned IDXV_W        = LANES * IDX_W;
  localparam int unsigned HDR_W         = 2 * IDXV_W + CW_W;

  // Packed from MSB down: width, column codes, row indices (row at bit 0).
  typedef struct packed {
    logic [CW_W-1:0]   width;
    logic [IDXV_W-1:0] col;
    logic [IDXV_W-1:0] row;
  } chunk_hdr_t;

  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_CHA = 2'd1,
    ST_CHB = 2'd2
  } dec_state_e;

  function automatic chunk_hdr_t hdr_slot(input logic [WORD_W-1:0] w,
                                          input int unsigned slot);
    return chunk_hdr_t'(w[slot*HDR_W +: HDR_W]);
  endfunction
endpackage

// File: rtl/sell_hdr_regs.sv
module sell_hdr_regs
  import sell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sel_b,
  output chunk_hdr_t        cur_o,
  output logic [CW_W-1:0]   width_b_o
);
  chunk_hdr_t slots [HDRS_PER_WORD];

  generate
    for (genvar g = 0; g < HDRS_PER_WORD; g++) begin : g_slot
      chunk_hdr_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q <= '0;
        end else if (load) begin
          slot_q <= hdr_slot(word_i, g);
        end
      end
      assign slots[g] = slot_q;
    end
  endgenerate

  assign cur_o     = sel_b ? slots[1] : slots[0];
  assign width_b_o = slots[1].width;
endmodule

// File: rtl/sell_chunk_seq.sv
module sell_chunk_seq
  import sell_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            in_valid,
  input  logic            out_ready,
  input  logic [CW_W-1:0] width_a_i,
  input  logic [CW_W-1:0] width_b_i,
  output dec_state_e      state_o,
  output logic            in_ready_o,
  output logic            hdr_load_o,
  output logic            present_o,
  output logic            last_o
);
  dec_state_e      state_q, state_d;
  logic [CW_W-1:0] remain_q, remain_d;
  logic            draining;
  logic            fire;
  logic            upd_en;

  always_comb begin
    draining   = (state_q != ST_HDR);
    in_ready_o = !start && (draining ? out_ready : 1'b1);
    hdr_load_o = !start && !draining && in_valid;
    present_o  = !start && draining && in_valid;
    fire       = present_o && out_ready;
    last_o     = fire && (remain_q == '0);
  end

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    if (start) begin
      state_d  = ST_HDR;
      remain_d = '0;
    end else begin
      unique case (state_q)
        ST_HDR: begin
          if (hdr_load_o) begin
            state_d  = ST_CHA;
            remain_d = width_a_i;
          end
        end
        ST_CHA: begin
          if (fire) begin
            if (last_o) begin
              state_d  = ST_CHB;
              remain_d = width_b_i;
            end else begin
              remain_d = remain_q - 1'b1;
            end
          end
        end
        ST_CHB: begin
          if (fire) begin
            if (last_o) begin
              state_d = ST_HDR;
            end else begin
              remain_d = remain_q - 1'b1;
            end
          end
        end
        default: begin
          state_d  = ST_HDR;
          remain_d = '0;
        end
      endcase
    end
  end

  assign upd_en = start || hdr_load_o || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HDR;
      remain_q <= '0;
    end else if (upd_en) begin
      state_q  <= state_d;
      remain_q <= remain_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sell_lane_fmt.sv
module sell_lane_fmt
  import sell_pkg::*;
(
  input  logic              draining,
  input  logic              present,
  input  chunk_hdr_t        hdr,
  input  logic [WORD_W-1:0] word,
  output logic [LANES-1:0]  lane_valid,
  output logic [IDXV_W-1:0] row_idx,
  output logic [IDXV_W-1:0] col_code,
  output logic [WORD_W-1:0] value
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_valid[k]              = present;
      assign row_idx[k*IDX_W +: IDX_W]  = draining ? hdr.row[k*IDX_W +: IDX_W] : '0;
      assign col_code[k*IDX_W +: IDX_W] = draining ? hdr.col[k*IDX_W +: IDX_W] : '0;
      assign value[k*VAL_W +: VAL_W]    = present  ? word[k*VAL_W +: VAL_W]    : '0;
    end
  endgenerate
endmodule

// File: rtl/sell_stream_decoder.sv
module sell_stream_decoder
  import sell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic [LANES-1:0]  lane_valid,
  output logic [IDXV_W-1:0] row_idx,
  output logic [IDXV_W-1:0] col_code,
  output logic [WORD_W-1:0] value,
  output logic              chunk_done
);
  dec_state_e      state;
  logic            hdr_load;
  logic            present;
  logic            last;
  chunk_hdr_t      cur_hdr;
  chunk_hdr_t      new_hdr_a;
  logic [CW_W-1:0] width_b;

  assign new_hdr_a = hdr_slot(in_data, 0);

  sell_hdr_regs i_hdr_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hdr_load),
    .word_i    (in_data),
    .sel_b     (state == ST_CHB),
    .cur_o     (cur_hdr),
    .width_b_o (width_b)
  );

  sell_chunk_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .width_a_i  (new_hdr_a.width),
    .width_b_i  (width_b),
    .state_o    (state),
    .in_ready_o (in_ready),
    .hdr_load_o (hdr_load),
    .present_o  (present),
    .last_o     (last)
  );

  sell_lane_fmt i_lanes (
    .draining   (state != ST_HDR),
    .present    (present),
    .hdr        (cur_hdr),
    .word       (in_data),
    .lane_valid (lane_valid),
    .row_idx    (row_idx),
    .col_code   (col_code),
    .value      (value)
  );

  assign chunk_done = last;
endmodule

// File: rtl/sell_decoder_chk.sv
module sell_decoder_chk
  import sell_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_ready,
  input logic [LANES-1:0]  lane_valid,
  input logic [IDXV_W-1:0] row_idx,
  input logic [IDXV_W-1:0] col_code,
  input logic              chunk_done
);
  AST_LANES_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid != '0) |-> in_valid); // R10
  AST_LANES_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid == '0) || (lane_valid == '1)); // R10
  AST_DONE_ON_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> (lane_valid == '1 && out_ready && in_ready)); // R7
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid != '0 && !out_ready) |-> !in_ready); // R8
  AST_STALL_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid != '0 && !out_ready && !start) |=> ($stable(row_idx) && $stable(col_code))); // R8
  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!in_ready && lane_valid == '0 && !chunk_done)); // R9
  AST_START_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (lane_valid == '0 && !chunk_done)); // R9
endmodule

bind sell_stream_decoder sell_decoder_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_ready  (out_ready),
  .lane_valid (lane_valid),
  .row_idx    (row_idx),
  .col_code   (col_code),
  .chunk_done (chunk_done)
);

// File: tb/test_sell_stream_decoder.sv
module test_sell_stream_decoder;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        in_valid;
  logic [63:0] in_data;
  logic        in_ready;
  logic        out_ready;
  logic [3:0]  lane_valid;
  logic [11:0] row_idx;
  logic [11:0] col_code;
  logic [63:0] value;
  logic        chunk_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int          m_st;   // 0 wait header, 1 chunk A, 2 chunk B
  int          m_rem;  // value words left after the current one
  logic [11:0] m_ra, m_ca, m_rb, m_cb;
  logic [1:0]  m_wb;

  sell_stream_decoder i_sell_stream_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_ready(out_ready),
    .lane_valid(lane_valid), .row_idx(row_idx), .col_code(col_code),
    .value(value), .chunk_done(chunk_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_hdr(input logic [11:0] ra, input logic [11:0] ca,
      input logic [1:0] wa, input logic [11:0] rb, input logic [11:0] cb,
      input logic [1:0] wb, input logic [11:0] junk);
    return {junk, wb, cb, rb, wa, ca, ra};
  endfunction

  task automatic step(input logic v, input logic [63:0] d, input logic r, input logic s);
    logic        e_ir;
    logic [3:0]  e_lv;
    logic        e_done;
    logic [11:0] e_row, e_col;
    logic [63:0] e_val;
    string       tag;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = r; start = s;
    #1;
    e_ir   = s ? 1'b0 : ((m_st == 0) ? 1'b1 : r);
    e_lv   = (!s && m_st != 0 && v) ? 4'hF : 4'h0;
    e_done = (e_lv != 0) && r && (m_rem == 0);
    e_row  = (m_st == 1) ? m_ra : (m_st == 2) ? m_rb : 12'h0;
    e_col  = (m_st == 1) ? m_ca : (m_st == 2) ? m_cb : 12'h0;
    e_val  = (e_lv != 0) ? d : 64'h0;
    tag = s ? "R9" : (m_st == 0) ? "R2" : "R8";
    chk(tag, "in_ready", {63'h0, in_ready}, {63'h0, e_ir});
    tag = s ? "R9" : (m_st == 0) ? "R2" : "R10";
    chk(tag, "lane_valid", {60'h0, lane_valid}, {60'h0, e_lv});
    chk(s ? "R9" : "R7", "chunk_done", {63'h0, chunk_done}, {63'h0, e_done});
    tag = (m_st == 1) ? "R4" : (m_st == 2) ? "R5" : "R1";
    chk(tag, "row_idx", {52'h0, row_idx}, {52'h0, e_row});
    chk("R3", "col_code", {52'h0, col_code}, {52'h0, e_col});
    chk("R6", "value", value, e_val);
    if (s) begin
      m_st = 0; m_rem = 0;
    end else if (m_st == 0 && v) begin
      m_ra = d[11:0];  m_ca = d[23:12]; m_rem = int'(d[25:24]);
      m_rb = d[37:26]; m_cb = d[49:38]; m_wb = d[51:50];
      m_st = 1;
    end else if (m_st != 0 && v && r) begin
      if (m_rem == 0) begin
        if (m_st == 1) begin m_st = 2; m_rem = int'(m_wb); end
        else m_st = 0;
      end else begin
        m_rem = m_rem - 1;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_st = 0; m_rem = 0; m_ra = 0; m_ca = 0; m_rb = 0; m_cb = 0; m_wb = 0;
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs while held in reset
    chk("R1", "in_ready in reset", {63'h0, in_ready}, 64'h1);
    chk("R1", "lane_valid in reset", {60'h0, lane_valid}, 64'h0);
    chk("R1", "chunk_done in reset", {63'h0, chunk_done}, 64'h0);
    chk("R1", "value in reset", value, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 64'h0, 1'b1, 1'b0);

    // Pattern 1: widths 1 and 4, junk in unused bits (R3, R4, R5)
    step(1'b1, mk_hdr(12'o7654, 12'o0123, 2'd0, 12'o1357, 12'o2460, 2'd3, 12'hFFF), 1'b1, 1'b0);
    for (int i = 0; i < 5; i++)
      step(1'b1, {16'h1000 + 16'(i), 16'h2000, 16'h3000, 16'h4000 + 16'(i)}, 1'b1, 1'b0);
    step(1'b0, 64'h0, 1'b1, 1'b0);

    // Pattern 2: widths 4 and 1 with backpressure (R8)
    step(1'b1, mk_hdr(12'o0011, 12'o2233, 2'd3, 12'o4455, 12'o6677, 2'd0, 12'hA5A), 1'b1, 1'b0);
    step(1'b1, 64'h1111_2222_3333_4444, 1'b1, 1'b0);
    step(1'b1, 64'h5555_6666_7777_8888, 1'b0, 1'b0);
    step(1'b1, 64'h5555_6666_7777_8888, 1'b0, 1'b0);
    step(1'b0, 64'h0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++)
      step(1'b1, {4{16'hC0DE ^ 16'(i)}}, 1'b1, 1'b0);
    step(1'b0, 64'h0, 1'b1, 1'b0);

    // Pattern 3: start in the middle of a chunk (R9)
    step(1'b1, mk_hdr(12'o1111, 12'o2222, 2'd2, 12'o3333, 12'o4444, 2'd2, 12'h000), 1'b1, 1'b0);
    step(1'b1, 64'hDEAD_BEEF_0000_0001, 1'b1, 1'b0);
    step(1'b1, 64'hDEAD_BEEF_0000_0002, 1'b1, 1'b1);
    step(1'b1, mk_hdr(12'o7070, 12'o0707, 2'd1, 12'o5252, 12'o2525, 2'd1, 12'h123), 1'b1, 1'b0);
    for (int i = 0; i < 4; i++)
      step(1'b1, {4{16'hF00D + 16'(i)}}, 1'b1, 1'b0);

    // Random traffic
    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) != 0, {$urandom, $urandom}, ($urandom % 3) != 0, ($urandom % 64) == 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule